// File: doc/BRIEF.md
# Serial Bus Transfer Status and Error-Flag Controller

This block tracks message status for a multi-master serial bus controller. It sits above a bit-level engine, which is not part of the project and appears here only as single-cycle event pulses. On the transmit side the block counts every data-byte attempt against a transfer budget, which the operating mode selects. It also counts the bytes that were actually acknowledged against the programmed message length.

A negative acknowledge on a data byte asks the engine to send the same byte again, and that repeat costs one more unit of the budget. The message ends in one of four ways: it completes, a header byte is refused, the last budgeted attempt is refused, or the budget runs out before the message is delivered. Each outcome raises its own combination of sticky flags. A raised transmit-end flag holds the transmitter in a wait state.

On the receive side the block raises flags for receive end, overrun and timing error, and it tracks whether a frame is in progress. Software clears any flag by writing a one to its bit.

Top module: `bus_xfer_flags`

## Requirements
- R1: After reset `flags` is 0, `tx_busy`, `retx_req` and `rx_active` are 0, and `tx_attempts` is 0. Flag bits are [0] transmit end, [1] budget overrun, [2] acknowledge error, [3] receive end, [4] receive overrun, [5] timing error.
- R2: A `tx_start` seen while idle with flag bit 0 clear sets `tx_busy` on the next cycle. At the same edge it zeroes `tx_attempts` and latches `msg_len` and `mode`. A `tx_start` while flag bit 0 is set has no effect.
- R3: A header acknowledge with `hdr_nak`=1 during a transfer sets flag bits 2 and 0 and clears `tx_busy`.
- R4: Every data acknowledge during a transfer increments `tx_attempts`. A NAK that neither ends the message nor exhausts the budget pulses `retx_req` high for exactly the following cycle.
- R5: A message is complete once its acknowledged byte count reaches the latched length. Completion sets only flag bit 0, including when some bytes were NAKed and then acknowledged on a repeat.
- R6: If the attempt that uses the last budget unit is NAKed, flag bits 0, 1 and 2 are set and the transfer ends.
- R7: If the budget runs out on an acknowledged attempt while bytes remain undelivered, flag bits 0 and 1 are set and bit 2 stays clear.
- R8: `mode` values 0 to 3 select budgets of 16, 32, 128 and 256 attempts, and `msg_len`=0 means 256 bytes. A length above the budget ends with bits 0 and 1 set after the budget is spent. A length equal to the budget that is fully acknowledged sets only bit 0.
- R9: A `rx_overrun` while `rx_active` sets flag bits 4 and 3 and leaves `rx_active` set.
- R10: A `rx_timing_err` while `rx_active` sets flag bits 5 and 3 and clears `rx_active`. While `rx_active` is low it sets no flag. While bit 5 is set, `rx_start` is ignored.
- R11: A `rx_start` while idle sets `rx_active`. A `rx_frame_end` while `rx_active` sets flag bit 3 and clears `rx_active`.
- R12: When `clr_wr` is high, each bit set in `clr_data` clears the flag at the same position. An event that sets a flag in the same cycle as its clear wins, so the flag reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Budget selector, latched at start |
| msg_len | input | 8 | Message length in bytes, 0 means 256, latched at start |
| tx_start | input | 1 | Request to begin a transmit frame |
| hdr_ack_evt | input | 1 | Pulse: acknowledge bit of a header field observed |
| hdr_nak | input | 1 | Header acknowledge was negative |
| data_ack_evt | input | 1 | Pulse: acknowledge bit of a data byte observed |
| data_nak | input | 1 | Data acknowledge was negative |
| rx_start | input | 1 | Pulse: reception of a frame begins |
| rx_overrun | input | 1 | Pulse: receive buffer overrun |
| rx_timing_err | input | 1 | Pulse: bit timing violation |
| rx_frame_end | input | 1 | Pulse: received frame ended |
| clr_wr | input | 1 | Write strobe for the flag-clear register |
| clr_data | input | 6 | One bit per flag to clear |
| flags | output | 6 | Sticky status flags |
| tx_busy | output | 1 | Transmit frame in progress |
| retx_req | output | 1 | Request to resend the current byte |
| rx_active | output | 1 | Reception in progress |
| tx_attempts | output | 9 | Data attempts in the current frame |

## Verification
The hazard that is easiest to miss is a software clear landing in the same cycle as a hardware event aimed at the same flag bit. The bench provokes it in three ways. It pulses `rx_frame_end` while writing a one to bit 3. It issues `tx_start` in the cycle that clears the transmit-end flag. It raises an overrun together with a clear of bit 4. A reference model computes the expected outcome from the requirements and is compared with every output on every clock. The expected results are: the flag reads set after the collision, and the start is refused because the flag was still set when it was sampled.

// File: rtl/bus_xfer_flags.sv
module bus_xfer_flags #(
  parameter int LEN_W  = 8,
  parameter int MAX_M0 = 16,
  parameter int MAX_M1 = 32,
  parameter int MAX_M2 = 128,
  parameter int MAX_M3 = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             tx_start,
  input  logic             hdr_ack_evt,
  input  logic             hdr_nak,
  input  logic             data_ack_evt,
  input  logic             data_nak,
  input  logic             rx_start,
  input  logic             rx_overrun,
  input  logic             rx_timing_err,
  input  logic             rx_frame_end,
  input  logic             clr_wr,
  input  logic [5:0]       clr_data,
  output logic [5:0]       flags,
  output logic             tx_busy,
  output logic             retx_req,
  output logic             rx_active,
  output logic [LEN_W:0]   tx_attempts
);
  localparam int CNT_W = LEN_W + 1;
  localparam int F_TXE = 0, F_RO = 1, F_ACK = 2, F_RXE = 3, F_OVR = 4, F_TIM = 5;

  logic [CNT_W-1:0] len_q, max_q, delivered, need_in, max_in, att_nx, del_nx;
  logic [5:0] set_vec, clr_mask;
  logic start_ok, tx_done, retx_now, rx_go, rx_stop;

  assign need_in  = (msg_len == '0) ? CNT_W'(1 << LEN_W) : CNT_W'(msg_len);
  assign start_ok = tx_start && !tx_busy && !flags[F_TXE];
  assign att_nx   = tx_attempts + 1'b1;
  assign del_nx   = delivered + CNT_W'(!data_nak);
  assign clr_mask = clr_wr ? clr_data : 6'd0;
  assign rx_go    = rx_start && !rx_active && !flags[F_TIM];
  assign rx_stop  = rx_active && (rx_timing_err || rx_frame_end);

  always_comb begin
    case (mode)
      2'd0:    max_in = CNT_W'(MAX_M0);
      2'd1:    max_in = CNT_W'(MAX_M1);
      2'd2:    max_in = CNT_W'(MAX_M2);
      default: max_in = CNT_W'(MAX_M3);
    endcase
  end

  always_comb begin
    set_vec  = '0;
    tx_done  = 1'b0;
    retx_now = 1'b0;
    if (tx_busy && hdr_ack_evt && hdr_nak) begin
      set_vec[F_TXE] = 1'b1;
      set_vec[F_ACK] = 1'b1;
      tx_done        = 1'b1;
    end else if (tx_busy && data_ack_evt) begin
      if (!data_nak && del_nx == len_q) begin
        set_vec[F_TXE] = 1'b1;
        tx_done        = 1'b1;
      end else if (att_nx == max_q) begin
        set_vec[F_TXE] = 1'b1;
        set_vec[F_RO]  = 1'b1;
        set_vec[F_ACK] = data_nak;
        tx_done        = 1'b1;
      end else begin
        retx_now = data_nak;
      end
    end
    if (rx_active && rx_overrun) begin
      set_vec[F_OVR] = 1'b1;
      set_vec[F_RXE] = 1'b1;
    end
    if (rx_active && rx_timing_err) begin
      set_vec[F_TIM] = 1'b1;
      set_vec[F_RXE] = 1'b1;
    end
    if (rx_active && rx_frame_end) set_vec[F_RXE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags       <= '0;
      tx_busy     <= 1'b0;
      retx_req    <= 1'b0;
      rx_active   <= 1'b0;
      tx_attempts <= '0;
      delivered   <= '0;
      len_q       <= '0;
      max_q       <= '0;
    end else begin
      flags    <= (flags & ~clr_mask) | set_vec;
      retx_req <= retx_now;
      if (start_ok) begin
        tx_busy     <= 1'b1;
        tx_attempts <= '0;
        delivered   <= '0;
        len_q       <= need_in;
        max_q       <= max_in;
      end else if (tx_busy) begin
        if (data_ack_evt && !(hdr_ack_evt && hdr_nak)) begin
          tx_attempts <= att_nx;
          delivered   <= del_nx;
        end
        if (tx_done) tx_busy <= 1'b0;
      end
      if (rx_stop)    rx_active <= 1'b0;
      else if (rx_go) rx_active <= 1'b1;
    end
  end
endmodule

module bus_xfer_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_start,
  input logic       hdr_ack_evt,
  input logic       hdr_nak,
  input logic       data_ack_evt,
  input logic       data_nak,
  input logic       rx_overrun,
  input logic       rx_timing_err,
  input logic [5:0] flags,
  input logic       tx_busy,
  input logic       retx_req,
  input logic       rx_active
);
  assert_wait_blocks_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && flags[0] && tx_start) |=> !tx_busy);

  assert_hdr_nak_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && hdr_ack_evt && hdr_nak) |=> (flags[2] && flags[0] && !tx_busy));

  assert_retx_follows_nak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> $past(tx_busy && data_ack_evt && data_nak && !(hdr_ack_evt && hdr_nak)));

  assert_ro_with_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> flags[0]);

  assert_overrun_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && rx_overrun) |=> (flags[4] && flags[3]));

  assert_timing_needs_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[5]) |-> $past(rx_active && rx_timing_err));
endmodule

bind bus_xfer_flags bus_xfer_flags_chk chk (.*);

// File: tb/bus_xfer_flags_test.sv
module bus_xfer_flags_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic [7:0] msg_len = 0;
  logic tx_start = 0, hdr_ack_evt = 0, hdr_nak = 0, data_ack_evt = 0, data_nak = 0;
  logic rx_start = 0, rx_overrun = 0, rx_timing_err = 0, rx_frame_end = 0, clr_wr = 0;
  logic [5:0] clr_data = 0;
  logic [5:0] flags;
  logic tx_busy, retx_req, rx_active;
  logic [8:0] tx_attempts;

  int checks = 0, errors = 0, retx_seen = 0;
  string cur_req = "R1";

  int m_flags = 0, m_busy = 0, m_retx = 0, m_rx = 0, m_att = 0, m_del = 0, m_need = 0, m_max = 0;
  int setm, retx_n;

  always #2 clk = ~clk;

  bus_xfer_flags uut (.*);

  function automatic int budget_of(input int md);
    return (md == 0) ? 16 : (md == 1) ? 32 : (md == 2) ? 128 : 256;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_busy = 0; m_retx = 0; m_rx = 0; m_att = 0; m_del = 0;
    end else begin
      setm = 0; retx_n = 0;
      if (m_busy != 0) begin
        if (hdr_ack_evt && hdr_nak) begin
          setm |= 5; m_busy = 0;
        end else if (data_ack_evt) begin
          m_att++;
          if (!data_nak) m_del++;
          if (!data_nak && m_del == m_need) begin setm |= 1; m_busy = 0; end
          else if (m_att == m_max) begin setm |= data_nak ? 7 : 3; m_busy = 0; end
          else if (data_nak) retx_n = 1;
        end
      end else if (tx_start && (m_flags & 1) == 0) begin
        m_busy = 1; m_att = 0; m_del = 0;
        m_need = (msg_len == 0) ? 256 : int'(msg_len);
        m_max = budget_of(int'(mode));
      end
      if (m_rx != 0) begin
        if (rx_overrun) setm |= 6'h18;
        if (rx_timing_err) begin setm |= 6'h28; m_rx = 0; end
        else if (rx_frame_end) begin setm |= 6'h08; m_rx = 0; end
      end else if (rx_start && (m_flags & 6'h20) == 0) m_rx = 1;
      m_flags = (m_flags & ~(clr_wr ? int'(clr_data) : 0)) | setm;
      m_retx = retx_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (retx_req) retx_seen++;
      chk(int'(flags) == m_flags, {cur_req, " flags"}, int'(flags), m_flags);
      chk(int'(tx_busy) == m_busy && int'(retx_req) == m_retx && int'(rx_active) == m_rx &&
          int'(tx_attempts) == m_att, {cur_req, " ctrl"},
          {tx_busy, retx_req, rx_active, tx_attempts}, (m_busy << 11) | (m_retx << 10) | (m_rx << 9) | m_att);
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic dack(input bit nak);
    @(negedge clk); data_ack_evt = 1; data_nak = nak;
    @(negedge clk); data_ack_evt = 0; data_nak = 0;
  endtask

  task automatic clear(input logic [5:0] m);
    @(negedge clk); clr_wr = 1; clr_data = m;
    @(negedge clk); clr_wr = 0; clr_data = 0;
  endtask

  task automatic begin_tx(input logic [1:0] md, input logic [7:0] len);
    mode = md; msg_len = len;
    pulse(tx_start);
    @(negedge clk); hdr_ack_evt = 1; hdr_nak = 0;
    @(negedge clk); hdr_ack_evt = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flags == 0 && !tx_busy && !rx_active && tx_attempts == 0, "R1 reset", int'(flags), 0);
    rst_n = 1;

    cur_req = "R5";
    retx_seen = 0;
    begin_tx(2'd0, 8'd3);
    chk(tx_busy == 1 && tx_attempts == 0, "R2 start", int'(tx_busy), 1);
    dack(0); dack(1); dack(0); dack(0);
    chk(flags == 6'h01 && !tx_busy, "R5 nak then ack completes", int'(flags), 1);
    chk(tx_attempts == 4 && retx_seen == 1, "R4 attempt count and retx", int'(tx_attempts), 4);

    cur_req = "R2";
    pulse(tx_start);
    chk(!tx_busy, "R2 start ignored in wait", int'(tx_busy), 0);
    @(negedge clk); tx_start = 1; clr_wr = 1; clr_data = 6'h01;
    @(negedge clk); tx_start = 0; clr_wr = 0; clr_data = 0;
    chk(!tx_busy && flags == 0, "R12 start same cycle as clear refused", int'(tx_busy), 0);

    cur_req = "R3";
    mode = 0; msg_len = 4;
    pulse(tx_start);
    @(negedge clk); hdr_ack_evt = 1; hdr_nak = 1;
    @(negedge clk); hdr_ack_evt = 0; hdr_nak = 0;
    chk(flags == 6'h05 && !tx_busy, "R3 header nak", int'(flags), 5);
    clear(6'h05);
    chk(flags == 0, "R12 clear", int'(flags), 0);

    cur_req = "R6";
    retx_seen = 0;
    begin_tx(2'd0, 8'd3);
    for (int i = 0; i < 16; i++) dack(1);
    chk(flags == 6'h07 && !tx_busy && tx_attempts == 16, "R6 last attempt nak", int'(flags), 7);
    chk(retx_seen == 15, "R4 retx per nak", retx_seen, 15);
    clear(6'h3f);

    cur_req = "R7";
    begin_tx(2'd0, 8'd5);
    for (int i = 0; i < 13; i++) dack(1);
    for (int i = 0; i < 3; i++) dack(0);
    chk(flags == 6'h03 && !tx_busy, "R7 budget out on ack", int'(flags), 3);
    clear(6'h3f);

    cur_req = "R8";
    begin_tx(2'd0, 8'd20);
    for (int i = 0; i < 16; i++) dack(0);
    chk(flags == 6'h03, "R8 length over budget", int'(flags), 3);
    clear(6'h3f);
    begin_tx(2'd1, 8'd32);
    for (int i = 0; i < 32; i++) dack(0);
    chk(flags == 6'h01 && tx_attempts == 32, "R8 length equals budget", int'(flags), 1);
    clear(6'h3f);
    begin_tx(2'd2, 8'd0);
    for (int i = 0; i < 128; i++) dack(0);
    chk(flags == 6'h03 && tx_attempts == 128, "R8 len 0 over mode 2", int'(flags), 3);
    clear(6'h3f);
    begin_tx(2'd3, 8'd0);
    for (int i = 0; i < 256; i++) dack(0);
    chk(flags == 6'h01 && tx_attempts == 256, "R8 len 0 in mode 3", int'(flags), 1);
    clear(6'h3f);

    cur_req = "R10";
    pulse(rx_timing_err);
    chk(flags == 0 && !rx_active, "R10 timing before start ignored", int'(flags), 0);

    cur_req = "R9";
    pulse(rx_start);
    chk(rx_active == 1, "R11 rx start", int'(rx_active), 1);
    pulse(rx_overrun);
    chk(flags == 6'h18 && rx_active, "R9 overrun", int'(flags), 24);
    @(negedge clk); rx_overrun = 1; clr_wr = 1; clr_data = 6'h10;
    @(negedge clk); rx_overrun = 0; clr_wr = 0; clr_data = 0;
    chk(flags[4] == 1, "R12 overrun beats clear", int'(flags), 24);
    clear(6'h18);

    cur_req = "R11";
    @(negedge clk); rx_frame_end = 1; clr_wr = 1; clr_data = 6'h08;
    @(negedge clk); rx_frame_end = 0; clr_wr = 0; clr_data = 0;
    chk(flags == 6'h08 && !rx_active, "R11 frame end, set beats clear", int'(flags), 8);
    clear(6'h08);

    cur_req = "R10";
    pulse(rx_start);
    pulse(rx_timing_err);
    chk(flags == 6'h28 && !rx_active, "R10 timing after start", int'(flags), 40);
    pulse(rx_start);
    chk(!rx_active, "R10 start ignored while timing flag", int'(rx_active), 0);
    clear(6'h3f);
    pulse(rx_start);
    chk(rx_active == 1 && flags == 0, "R10 start after clear", int'(rx_active), 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule